// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is a target on a two-wire open-drain bus. It gives a bus controller access to a small bank of byte-wide registers that sits outside the block. A fast system clock oversamples both bus lines. The block finds START, repeated START and STOP conditions and takes one bit per SCL clock. It answers only to the fixed 7-bit address 7'b0010000, which is 0x20 once the R/W bit is appended.

A write transaction works as follows. The first data byte sets an internal register pointer. Each later byte is written to the register the pointer selects, and the pointer then steps forward. A read transaction returns the register at the pointer, MSB first, and steps the pointer after every byte. Reading continues for as long as the controller acknowledges.

The block drives the bus only through an active-high pull-down enable, so it never drives the data line high. The register side is a plain port: a one-cycle write strobe, a pointer output and a combinational read-data input.

Top module: `i2c_regbank_target`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception from any state, and a STOP (SDA rising while SCL is high) returns the block to idle.
- R2: When the address byte carries 7'b0010000, the block holds SDA low for the whole high time of the 9th SCL clock.
- R3: Any other address gets no acknowledge. The block then pulls nothing and writes nothing until the next START or STOP.
- R4: In a write, the first data byte loads the pointer and every later byte is written to the register at the pointer, which then steps by one and wraps at the bank size. Every data byte is acknowledged.
- R5: With R/W=1, the register at the pointer is returned MSB first. SDA changes only while SCL is low, and the pointer steps by one after each byte read.
- R6: In a read, a low 9th bit from the controller makes the next byte follow. A high 9th bit releases SDA until a STOP or a START.
- R7: A repeated START restarts address reception without passing through idle and keeps the pointer.
- R8: A STOP in the middle of a byte aborts the transfer and writes no register from the partial byte.
- R9: A STOP in the same SCL-high interval as a START is ignored, and the address byte that follows is still taken.
- R10: After reset the pull-down enable and the write strobe are low.
- R11: The write strobe is high for exactly one system clock per register written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | High pulls the data line low |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | PTR_W | Register pointer, used for both reads and writes |
| reg_wdata_o | output | 8 | Data to be written |
| reg_rdata_i | input | 8 | Contents of the register at reg_addr_o |

## Verification
The bench builds the block with its default parameters: a 4-bit pointer, which gives a 16-entry bank, and two synchroniser stages. With these values all 128 seven-bit addresses can be swept, so exactly one of them is expected to be acknowledged. A 16-byte burst passes the pointer through its wrap point and touches every register, in writing and again in reading. Directed sequences cover the remaining cases: the START followed by a STOP in the same SCL-high interval, the mid-byte STOP and the traffic after a NACK.

// File: rtl/i2c_tgt_pkg.sv
// Package: types and constants shared by the bus target.
// Assumes byte-wide registers and a fixed device address.
package i2c_tgt_pkg;

    localparam int        BYTE_W   = 8;
    localparam logic [6:0] DEV_ADDR = 7'b0010000;

    typedef enum logic [2:0] {
        ST_IDLE,   // bus free or not addressed
        ST_ADDR,   // shifting in the address byte
        ST_ACK,    // 9th clock of an acknowledged byte
        ST_WR,     // shifting in a write data byte
        ST_RD,     // shifting out a read data byte
        ST_RACK,   // sampling controller ACK/NACK
        ST_SKIP    // ignoring traffic until START/STOP
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchroniser: brings W asynchronous lines into the clk domain
// through STAGES flops and also gives the previous synced sample.
// Assumes lines idle high, so every stage resets to 1.
module i2c_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] lvl_d_o
);

    logic [W-1:0] stage_q [STAGES];

    // first stage captures the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '1;
        else        stage_q[0] <= raw_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_chain
            // each further stage re-registers its predecessor
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign lvl_o = stage_q[STAGES-1];

    // delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d_o <= '1;
        else        lvl_d_o <= lvl_o;
    end

endmodule

// File: rtl/i2c_cond_detect.sv
// Condition detector: derives the SCL edges and the bus START and STOP
// events from the synced and delayed line samples.
// A STOP seen in the same SCL-high interval as a START is suppressed.
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic scl_d,
    input  logic sda,
    input  logic sda_d,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic raw_start, raw_stop, start_in_high_q;

    assign scl_rise_o = scl & ~scl_d;
    assign scl_fall_o = ~scl & scl_d;
    assign raw_start  = scl & scl_d & sda_d & ~sda;
    assign raw_stop   = scl & scl_d & ~sda_d & sda;

    // remember a START until SCL leaves its high phase
    always_ff @(posedge clk) begin
        if (!rst_n)         start_in_high_q <= 1'b0;
        else if (raw_start) start_in_high_q <= 1'b1;
        else if (!scl)      start_in_high_q <= 1'b0;
    end

    assign start_o = raw_start;
    assign stop_o  = raw_stop & ~start_in_high_q;

endmodule

// File: rtl/i2c_target_fsm.sv
// Byte engine: receives the address and write bytes, serialises the
// read bytes, produces the ACK pull-down and keeps the register pointer.
// Assumes one-cycle event strobes from the condition detector and
// combinational read data for the current pointer.
module i2c_target_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              pull_o,
    output logic              we_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic [PTR_W-1:0]  ptr_o
);

    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W);

    tgt_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              rw_q;
    logic              nack_q;
    logic              ptr_set_q;

    // protocol sequencer, pointer and register strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            shreg_q   <= '0;
            rw_q      <= 1'b0;
            nack_q    <= 1'b0;
            ptr_set_q <= 1'b0;
            pull_o    <= 1'b0;
            we_o      <= 1'b0;
            wdata_o   <= '0;
            ptr_o     <= '0;
        end else begin
            we_o <= 1'b0;
            if (we_o) ptr_o <= ptr_o + 1'b1;

            if (start_evt) begin
                state_q   <= ST_ADDR;
                cnt_q     <= '0;
                pull_o    <= 1'b0;
                ptr_set_q <= 1'b0;
            end else if (stop_evt) begin
                state_q <= ST_IDLE;
                pull_o  <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise && cnt_q != BYTE_END) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == BYTE_END) begin
                            cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (shreg_q[BYTE_W-1:1] == DEV_ADDR) begin
                                    pull_o  <= 1'b1;
                                    rw_q    <= shreg_q[0];
                                    state_q <= ST_ACK;
                                end else begin
                                    state_q <= ST_SKIP;
                                end
                            end else begin
                                pull_o  <= 1'b1;
                                state_q <= ST_ACK;
                                if (!ptr_set_q) begin
                                    ptr_o     <= shreg_q[PTR_W-1:0];
                                    ptr_set_q <= 1'b1;
                                end else begin
                                    we_o    <= 1'b1;
                                    wdata_o <= shreg_q;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                shreg_q <= rdata_i;
                                pull_o  <= ~rdata_i[BYTE_W-1];
                                ptr_o   <= ptr_o + 1'b1;
                                state_q <= ST_RD;
                            end else begin
                                pull_o  <= 1'b0;
                                state_q <= ST_WR;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt_q == BYTE_END) begin
                                pull_o  <= 1'b0;
                                state_q <= ST_RACK;
                            end else begin
                                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                                pull_o  <= ~shreg_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            nack_q <= sda;
                        end else if (scl_fall) begin
                            cnt_q <= '0;
                            if (!nack_q) begin
                                shreg_q <= rdata_i;
                                pull_o  <= ~rdata_i[BYTE_W-1];
                                ptr_o   <= ptr_o + 1'b1;
                                state_q <= ST_RD;
                            end else begin
                                state_q <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regbank_target.sv
// Top: bus target for a register bank. Synchronises the lines, finds
// bus conditions and runs the byte engine. sda_pull_o is a pull-down
// enable for an open-drain pad; the bank itself lives outside.
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              reg_we_o,
    output logic [PTR_W-1:0]  reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);

    logic [1:0] lvl, lvl_d;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({scl_i, sda_i}),
        .lvl_o   (lvl),
        .lvl_d_o (lvl_d)
    );

    assign scl_s = lvl[1];
    assign sda_s = lvl[0];

    i2c_cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl        (scl_s),
        .scl_d      (lvl_d[1]),
        .sda        (sda_s),
        .sda_d      (lvl_d[0]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    i2c_target_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda       (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rdata_i   (reg_rdata_i),
        .pull_o    (sda_pull_o),
        .we_o      (reg_we_o),
        .wdata_o   (reg_wdata_o),
        .ptr_o     (reg_addr_o)
    );

endmodule

// File: rtl/i2c_regbank_target_chk.sv
// Checker: temporal properties of the bus target, bound to the top.
// Assumes a well-formed controller that never starts or stops while
// the target is pulling the data line.
module i2c_regbank_target_chk #(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             start_evt,
    input logic             stop_evt,
    input logic             sda_pull_o,
    input logic             reg_we_o,
    input logic [PTR_W-1:0] reg_addr_o
);

    // the data line driver only moves while SCL is low
    assert_pull_moves_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_s);

    // a STOP leaves the line released
    assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull_o);

    // a START leaves the line released while the address arrives
    assert_start_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_pull_o);

    // write strobe lasts a single cycle
    assert_we_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    // pointer steps by one after a register write
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> (reg_addr_o == PTR_W'($past(reg_addr_o) + 1'b1)));

endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .sda_pull_o (sda_pull_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o)
);

// File: tb/i2c_regbank_target_bench.sv
module i2c_regbank_target_bench;

    localparam int PTR_W = 4;
    localparam int NREG  = 1 << PTR_W;
    localparam int Q     = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl_m = 1'b1;
    logic             sda_m = 1'b1;
    logic             sda_line;
    logic             sda_pull_o, reg_we_o;
    logic [PTR_W-1:0] reg_addr_o;
    logic [7:0]       reg_wdata_o, reg_rdata_i;

    logic [7:0] bank [NREG];
    logic [7:0] expv [NREG];
    int checks = 0, fails = 0, we_cnt = 0, we_long = 0, exp_writes = 0;
    logic we_prev = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line    = sda_m & ~sda_pull_o;
    assign reg_rdata_i = bank[reg_addr_o];

    i2c_regbank_target #(.PTR_W(PTR_W), .SYNC_STAGES(2)) u_i2c_regbank_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull_o),
        .reg_we_o    (reg_we_o),
        .reg_addr_o  (reg_addr_o),
        .reg_wdata_o (reg_wdata_o),
        .reg_rdata_i (reg_rdata_i)
    );

    // register storage modelled by the bench
    always @(posedge clk) if (rst_n && reg_we_o) bank[reg_addr_o] <= reg_wdata_o;

    // strobe monitor
    always @(negedge clk) begin
        if (rst_n && reg_we_o) we_cnt++;
        if (rst_n && reg_we_o && we_prev) we_long++;
        we_prev <= reg_we_o;
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    // sends a byte, returns 1 when SDA stays low across the whole 9th high
    task automatic write_byte(input logic [7:0] b, output logic acked);
        logic s0, s1;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(); scl_m = 1'b1;
        @(negedge clk); s0 = sda_line;
        wq(); repeat (Q - 1) @(negedge clk); s1 = sda_line;
        scl_m = 1'b0; wq();
        acked = !s0 && !s1;
    endtask

    // reads a byte, reports whether any bit moved during SCL high
    task automatic read_byte(input logic ack, output logic [7:0] d, output logic moved);
        logic a, b;
        moved = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(); scl_m = 1'b1;
            @(negedge clk); a = sda_line;
            wq(); repeat (Q - 1) @(negedge clk); b = sda_line;
            scl_m = 1'b0; wq();
            d[i] = a;
            if (a !== b) moved = 1'b1;
        end
        sda_m = ~ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic       ak, mv;
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) begin bank[i] = 8'h00; expv[i] = 8'h00; end
        repeat (5) @(negedge clk);
        chk("R10 pull after reset", sda_pull_o, 0);
        chk("R10 strobe after reset", reg_we_o, 0);
        rst_n = 1'b1;
        wq();
        chk("R10 pull idle", sda_pull_o, 0);

        // R2/R3: sweep all addresses with R/W=0
        for (int a = 0; a < 128; a++) begin
            bus_start();
            write_byte({7'(a), 1'b0}, ak);
            chk($sformatf("R2 R3 ack for address %0h", a), ak, (a == 16) ? 1 : 0);
            bus_stop();
        end

        // R3: traffic after a mismatch is ignored
        bus_start();
        write_byte(8'h22, ak); chk("R3 mismatch no ack", ak, 0);
        write_byte(8'h00, ak); chk("R3 ignored pointer byte", ak, 0);
        write_byte(8'hAA, ak); chk("R3 ignored data byte", ak, 0);
        bus_stop();
        chk("R3 no write", we_cnt, 0);

        // R4: pointer at 3, sixteen bytes wrap through all registers
        bus_start();
        write_byte(8'h20, ak); chk("R2 write address ack", ak, 1);
        write_byte(8'h03, ak); chk("R4 pointer byte ack", ak, 1);
        for (int i = 0; i < NREG; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + 5) & 8'hFF);
            write_byte(v, ak);
            chk($sformatf("R4 data ack %0d", i), ak, 1);
            expv[(i + 3) % NREG] = v;
            exp_writes++;
        end
        bus_stop();
        for (int i = 0; i < NREG; i++) chk($sformatf("R4 bank[%0d]", i), bank[i], expv[i]);

        // R5/R6/R7: set pointer 0, repeated START, read all with final NACK
        bus_start();
        write_byte(8'h20, ak); chk("R7 address ack", ak, 1);
        write_byte(8'h00, ak); chk("R7 pointer ack", ak, 1);
        bus_start();
        write_byte(8'h21, ak); chk("R7 read address ack after Sr", ak, 1);
        for (int i = 0; i < NREG; i++) begin
            read_byte(i != NREG - 1, d, mv);
            chk($sformatf("R5 read byte %0d", i), d, expv[i]);
            chk($sformatf("R5 stable in high %0d", i), mv, 0);
        end
        // R6: after NACK the line stays released
        begin
            int low_seen = 0;
            for (int i = 0; i < 9; i++) begin
                sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
                if (sda_line !== 1'b1) low_seen++;
                wq(); scl_m = 1'b0; wq();
            end
            chk("R6 released after NACK", low_seen, 0);
        end
        bus_stop();

        // R6: ACK on a short read continues with next register (pointer moved)
        bus_start();
        write_byte(8'h20, ak);
        write_byte(8'h05, ak);
        bus_start();
        write_byte(8'h21, ak);
        read_byte(1'b1, d, mv); chk("R6 first after ack", d, expv[5]);
        read_byte(1'b0, d, mv); chk("R6 second after ack", d, expv[6]);
        bus_stop();

        // R8: STOP in the middle of a data byte
        bus_start();
        write_byte(8'h20, ak);
        write_byte(8'h05, ak);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        wq();
        chk("R8 no write on abort", we_cnt, exp_writes);
        chk("R8 register kept", bank[5], expv[5]);
        chk("R8 line released", sda_pull_o, 0);
        chk("R1 idle after stop", sda_line, 1);

        // R9: START then STOP in one SCL high, address still taken
        scl_m = 1'b1; sda_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        sda_m = 1'b1; wq();
        scl_m = 1'b0; wq();
        write_byte(8'h20, ak); chk("R9 stop ignored, address ack", ak, 1);
        write_byte(8'h07, ak);
        write_byte(8'h5A, ak); chk("R9 data ack", ak, 1);
        expv[7] = 8'h5A; exp_writes++;
        bus_stop();
        wq();
        chk("R9 register written", bank[7], 8'h5A);

        chk("R11 strobe count", we_cnt, exp_writes);
        chk("R11 no long strobe", we_long, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule